// File: doc/BRIEF.md
# Serial receiver with wakeup

This block turns an asynchronous serial line into parallel characters of 8 or 9 bits. A line-rate tick at sixteen times the bit rate paces it. The line sits high when idle. A frame is one low start bit, then the data bits least significant first, then one high stop bit. Each character can carry an odd or even parity bit in its top position, and the block checks that bit.

The receiver has a sleep state for multi-drop links. A node that sees a message is not meant for it asks to sleep. While asleep, characters are still framed but none is handed on. Either of two conditions clears the sleep state, chosen by a control input. The first is a character whose top bit is 1, which acts as an address mark; that character is itself delivered. The second is an idle line: a full character length of continuous 1s.

A second control picks where the idle count may begin. It can start right after a start bit, so trailing 1 data bits and the stop bit already count toward idle. Or it can start only after the stop bit has been sampled. The first choice finds idle sooner but can be fooled by characters that end in 1s. The second waits longer but only counts true gaps between frames.

Top module: `serial_wake_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rx_valid`, `par_err`, `frame_err`, `idle_seen` and `asleep` are 0 after that edge, and `rx_data` is 0, even with `sleep_req` held high.
- R2: A falling line is taken as a start bit only if it still reads 0 at the 8th oversample tick. A low pulse of a few ticks produces no character.
- R3: A frame with a 0 start bit, data least significant bit first and a stop bit produces one `rx_valid` pulse of one clock, with the character on `rx_data`. In 8-bit mode (`nine_bit`=0) eight data bits are taken and `rx_data[8]` is 0. In 9-bit mode nine bits are taken.
- R4: With `par_en`=1, `par_err` pulses together with `rx_valid` when the number of 1s over all character bits, including the top bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode), is odd while `par_odd`=0, or even while `par_odd`=1. With `par_en`=0 it stays 0.
- R5: A stop bit sampled as 0 pulses `frame_err` together with `rx_valid`, and the character is still delivered.
- R6: `idle_seen` pulses for one clock after continuous 1s lasting 10 bit times in 8-bit mode or 11 bit times in 9-bit mode. It pulses at most once per high period.
- R7: With `idle_after_stop`=0, counting runs from the end of the start bit, so 1 data bits and the stop bit count toward idle.
- R8: With `idle_after_stop`=1, counting begins only once the stop bit has been sampled.
- R9: A one-clock `sleep_req` sets `asleep`. While asleep, no `rx_valid`, `par_err` or `frame_err` is produced, except for a character that wakes the receiver under R10.
- R10: With `wake_addr`=1, a character whose top bit (bit 7 or bit 8 by mode) is 1 clears `asleep` and is delivered. A character with that bit at 0 leaves the receiver asleep.
- R11: With `wake_addr`=0, an `idle_seen` pulse clears `asleep`. A character with its top bit at 1 does not wake the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| os_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial receive line, high when idle |
| nine_bit | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| par_en | input | 1 | 1 enables the parity check on the top bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| wake_addr | input | 1 | 1 selects address-mark wakeup, 0 selects idle-line wakeup |
| idle_after_stop | input | 1 | 1 starts idle counting after the stop bit, 0 after the start bit |
| sleep_req | input | 1 | One-clock request to enter the sleep state |
| rx_data | output | 9 | Last delivered character |
| rx_valid | output | 1 | One-clock pulse when a character is delivered |
| par_err | output | 1 | Parity error, aligned with `rx_valid` |
| frame_err | output | 1 | Stop bit read as 0, aligned with `rx_valid` |
| idle_seen | output | 1 | One-clock pulse when an idle line is recognised |
| asleep | output | 1 | Receiver is in the sleep state |

## Verification
The bench sends the same all-ones character with idle counting from the start bit and then from the stop bit, and checks a window in which only the first setting may already have flagged idle. A design that began counting at the wrong point would flag idle early in the second case or late in the first. It checks the 10 and 11 bit-time idle lengths on either side of their edges, and checks that idle fires only once per high period. A receiver that re-fires would wake a sleeping node on a line that never dropped. In sleep it sends a non-marked character followed by a marked one in both character widths, and a marked character in idle-wake mode. A design that decoded the wrong top bit, dropped the waking character or let a mark wake the idle mode fails these checks. Short low glitches, a stop bit forced low and parity cases of both senses cover start qualification and flag alignment.

// File: rtl/swr_pkg.sv
// Shared types for the serial receiver with wakeup.
package swr_pkg;
    // Phase of the frame deserializer.
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/swr_sync.sv
// Line synchronizer: brings the asynchronous receive line into the clock
// domain through a chain of flops.
// Assumes STAGES >= 2; the chain resets to 1, the idle line level.
module swr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/swr_frame.sv
// Frame deserializer. Finds a start bit, checks it at mid-bit, then takes one
// sample per bit at the bit centre, least significant bit first, and finally
// samples the stop bit.
// Assumes the line is already synchronized and that os_tick is a one-clock
// pulse at OVS times the bit rate. The character length is latched when the
// start bit is accepted.
module swr_frame
    import swr_pkg::*;
#(
    parameter int OVS      = 16,
    parameter int CHAR_MAX = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic                nine_bit,
    output logic                frame_done,
    output logic [CHAR_MAX-1:0] char_q,
    output logic                char_long,
    output logic                stop_ok,
    output logic                in_idle
);
    localparam int TCNT_W   = $clog2(OVS);
    localparam int IDX_W    = $clog2(CHAR_MAX);
    localparam int MID_WAIT = OVS / 2 - 1;

    localparam logic [TCNT_W-1:0] T_MID   = TCNT_W'(MID_WAIT - 1);
    localparam logic [TCNT_W-1:0] T_FULL  = TCNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0]  I_LONG  = IDX_W'(CHAR_MAX - 1);
    localparam logic [IDX_W-1:0]  I_SHORT = IDX_W'(CHAR_MAX - 2);

    rx_state_e         state;
    logic [TCNT_W-1:0] tcnt;
    logic [IDX_W-1:0]  bidx;
    logic [IDX_W-1:0]  last_idx;

    // Index of the final data bit for the latched character length.
    always_comb begin
        last_idx = char_long ? I_LONG : I_SHORT;
    end

    // Advance the frame state machine on each oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RX_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            char_long  <= 1'b0;
            char_q     <= '0;
            stop_ok    <= 1'b1;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!line) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == T_MID) begin
                            tcnt <= '0;
                            if (!line) begin
                                state     <= RX_DATA;
                                bidx      <= '0;
                                char_long <= nine_bit;
                                char_q    <= '0;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == T_FULL) begin
                            tcnt         <= '0;
                            char_q[bidx] <= line;
                            if (bidx == last_idx) state <= RX_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == T_FULL) begin
                            tcnt       <= '0;
                            stop_ok    <= line;
                            frame_done <= 1'b1;
                            state      <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assign in_idle = (state == RX_IDLE);
endmodule

// File: rtl/swr_idle.sv
// Idle-line detector. Counts oversample ticks of a high line and raises a
// one-clock pulse once a full character length of 1s has passed, then stays
// quiet until the line goes low again.
// Assumes after_stop=1 means counting is allowed only while the deserializer
// waits for a start bit, that is after the stop bit has been sampled.
module swr_idle #(
    parameter int OVS      = 16,
    parameter int CHAR_MAX = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line,
    input  logic nine_bit,
    input  logic after_stop,
    input  logic in_idle,
    output logic idle_hit
);
    localparam int LONG_TICKS  = (CHAR_MAX + 2) * OVS;
    localparam int SHORT_TICKS = (CHAR_MAX + 1) * OVS;
    localparam int CNT_W       = $clog2(LONG_TICKS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic             fired;

    // Last count value before the idle length is reached.
    always_comb begin
        limit = nine_bit ? CNT_W'(LONG_TICKS - 1) : CNT_W'(SHORT_TICKS - 1);
    end

    // Count consecutive high ticks and flag one idle per high period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            fired    <= 1'b0;
            idle_hit <= 1'b0;
        end else begin
            idle_hit <= 1'b0;
            if (tick) begin
                if (!line) begin
                    cnt   <= '0;
                    fired <= 1'b0;
                end else if (after_stop && !in_idle) begin
                    cnt <= '0;
                end else if (!fired) begin
                    if (cnt == limit) begin
                        idle_hit <= 1'b1;
                        fired    <= 1'b1;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/swr_wake.sv
// Sleep and wake control. Holds the sleep state, decides which received
// characters are delivered and clears sleep on the selected wake condition.
// Assumes frame_done and idle_hit are one-clock pulses; a wake condition
// takes priority over a sleep request in the same clock.
module swr_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic wake_addr,
    input  logic frame_done,
    input  logic char_msb,
    input  logic idle_hit,
    output logic asleep,
    output logic deliver
);
    logic mark_wake;
    logic line_wake;

    // Decode the two wake conditions and the delivery gate.
    always_comb begin
        mark_wake = asleep && wake_addr && frame_done && char_msb;
        line_wake = asleep && !wake_addr && idle_hit;
        deliver   = frame_done && (!asleep || mark_wake);
    end

    // Update the sleep state.
    always_ff @(posedge clk) begin
        if (!rst_n)                      asleep <= 1'b0;
        else if (mark_wake || line_wake) asleep <= 1'b0;
        else if (sleep_req)              asleep <= 1'b1;
    end
endmodule

// File: rtl/serial_wake_rx.sv
// Serial receiver with wakeup, top level. Synchronizes the line, deserializes
// frames, checks parity on the top character bit, detects idle lines and
// gates delivery through the sleep state. All outputs are registered.
// Assumes os_tick is a one-clock pulse at OVS times the bit rate and that
// the controls are stable while a frame is in flight.
module serial_wake_rx #(
    parameter int OVS         = 16,
    parameter int CHAR_MAX    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rx_in,
    input  logic                nine_bit,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic                wake_addr,
    input  logic                idle_after_stop,
    input  logic                sleep_req,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                par_err,
    output logic                frame_err,
    output logic                idle_seen,
    output logic                asleep
);
    logic                line_s;
    logic                frame_done;
    logic [CHAR_MAX-1:0] char_q;
    logic                char_long;
    logic                stop_ok;
    logic                in_idle;
    logic                idle_hit;
    logic                deliver;
    logic                char_msb;
    logic                bad_parity;

    swr_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_in),
        .q     (line_s)
    );

    swr_frame #(.OVS(OVS), .CHAR_MAX(CHAR_MAX)) frame_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line_s),
        .nine_bit   (nine_bit),
        .frame_done (frame_done),
        .char_q     (char_q),
        .char_long  (char_long),
        .stop_ok    (stop_ok),
        .in_idle    (in_idle)
    );

    swr_idle #(.OVS(OVS), .CHAR_MAX(CHAR_MAX)) idle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line_s),
        .nine_bit   (nine_bit),
        .after_stop (idle_after_stop),
        .in_idle    (in_idle),
        .idle_hit   (idle_hit)
    );

    // Top character bit and parity result for the finished frame.
    always_comb begin
        char_msb   = char_long ? char_q[CHAR_MAX-1] : char_q[CHAR_MAX-2];
        bad_parity = par_en && ((^char_q) ^ par_odd);
    end

    swr_wake wake_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .wake_addr  (wake_addr),
        .frame_done (frame_done),
        .char_msb   (char_msb),
        .idle_hit   (idle_hit),
        .asleep     (asleep),
        .deliver    (deliver)
    );

    // Register the delivered character, its flags and the idle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            par_err   <= 1'b0;
            frame_err <= 1'b0;
            idle_seen <= 1'b0;
        end else begin
            rx_valid  <= deliver;
            par_err   <= deliver && bad_parity;
            frame_err <= deliver && !stop_ok;
            idle_seen <= idle_hit;
            if (deliver) rx_data <= char_q;
        end
    end
endmodule

// Property checker for serial_wake_rx, attached through bind below.
module serial_wake_rx_chk #(
    parameter int CHAR_MAX = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                nine_bit,
    input logic                wake_addr,
    input logic [CHAR_MAX-1:0] rx_data,
    input logic                rx_valid,
    input logic                par_err,
    input logic                frame_err,
    input logic                idle_seen,
    input logic                asleep
);
    logic out_msb;

    // Top bit of the delivered character for the current mode.
    always_comb begin
        out_msb = nine_bit ? rx_data[CHAR_MAX-1] : rx_data[CHAR_MAX-2];
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && !asleep && !idle_seen && !par_err && !frame_err));

    assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_short_top_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !nine_bit) |-> !rx_data[CHAR_MAX-1]);

    assert_parity_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> rx_valid);

    assert_frame_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> rx_valid);

    assert_idle_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        idle_seen |=> !idle_seen);

    assert_woken_delivery_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(asleep)) |-> !asleep);

    assert_mark_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(asleep)) |-> (wake_addr && out_msb));

    assert_wake_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (rx_valid || idle_seen));
endmodule

bind serial_wake_rx serial_wake_rx_chk #(.CHAR_MAX(CHAR_MAX)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .nine_bit  (nine_bit),
    .wake_addr (wake_addr),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .par_err   (par_err),
    .frame_err (frame_err),
    .idle_seen (idle_seen),
    .asleep    (asleep)
);

// File: tb/serial_wake_rx_tb_top.sv
// Self-checking bench for serial_wake_rx: a vector table of frames, then
// directed tests for reset, noise, idle timing and wakeup.
module serial_wake_rx_tb_top;
    localparam int BIT_CLK = 64;  // 16 ticks of 4 clocks each
    localparam int NVEC    = 11;

    // {nine_bit, par_en, par_odd, data[8:0], stop_low, exp_par_err, exp_frame_err}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 9'h055, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 9'h003, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 9'h007, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 9'h007, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b1, 9'h081, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 9'h1A5, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 9'h101, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 9'h100, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 9'h0A3, 1'b1, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b0, 9'h0FF, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 9'h0FF, 1'b0, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       nine_bit = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       wake_addr = 1'b0;
    logic       idle_after_stop = 1'b0;
    logic       sleep_req = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       par_err;
    logic       frame_err;
    logic       idle_seen;
    logic       asleep;

    int         n_run = 0;
    int         n_fail = 0;
    int         vcnt = 0;
    int         icnt = 0;
    logic [8:0] last_data = '0;
    logic       last_pe = 1'b0;
    logic       last_fe = 1'b0;
    logic [1:0] tdiv = '0;

    serial_wake_rx dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .os_tick         (os_tick),
        .rx_in           (rx_in),
        .nine_bit        (nine_bit),
        .par_en          (par_en),
        .par_odd         (par_odd),
        .wake_addr       (wake_addr),
        .idle_after_stop (idle_after_stop),
        .sleep_req       (sleep_req),
        .rx_data         (rx_data),
        .rx_valid        (rx_valid),
        .par_err         (par_err),
        .frame_err       (frame_err),
        .idle_seen       (idle_seen),
        .asleep          (asleep)
    );

    always #4 clk = ~clk;

    // Oversample tick every fourth clock, driven away from the active edge.
    always @(negedge clk) begin
        tdiv    = tdiv + 2'd1;
        os_tick = (tdiv == 2'd0);
    end

    // Output monitor: counts deliveries and idle pulses.
    always @(negedge clk) begin
        if (rx_valid) begin
            vcnt      = vcnt + 1;
            last_data = rx_data;
            last_pe   = par_err;
            last_fe   = frame_err;
        end
        if (idle_seen) icnt = icnt + 1;
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input int nb, input logic [8:0] d, input bit stop_low);
        rx_in = 1'b0;
        hold(BIT_CLK);
        for (int b = 0; b < nb; b++) begin
            rx_in = d[b];
            hold(BIT_CLK);
        end
        if (stop_low) begin
            rx_in = 1'b0;
            hold(44);
            rx_in = 1'b1;
            hold(BIT_CLK - 44);
        end else begin
            rx_in = 1'b1;
            hold(BIT_CLK);
        end
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        hold(1);
        sleep_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [14:0] v;
        int v0;
        int i0;

        // R1: reset state, with a sleep request held during reset.
        sleep_req = 1'b1;
        hold(10);
        check_eq("R1 rx_valid", int'(rx_valid), 0);
        check_eq("R1 asleep", int'(asleep), 0);
        check_eq("R1 idle_seen", int'(idle_seen), 0);
        check_eq("R1 rx_data", int'(rx_data), 0);
        sleep_req = 1'b0;
        rst_n = 1'b1;

        // R6: idle length in 8-bit mode and a single pulse per high period.
        hold(8 * BIT_CLK);
        check_eq("R6 no idle before 10 bits", icnt, 0);
        hold(22 * BIT_CLK);
        check_eq("R6 one idle per high period", icnt, 1);

        // R3 R4 R5: vector table of frames.
        for (int i = 0; i < NVEC; i++) begin
            v        = VEC[i];
            nine_bit = v[14];
            par_en   = v[13];
            par_odd  = v[12];
            hold(BIT_CLK);
            v0 = vcnt;
            send_frame(v[14] ? 9 : 8, v[11:3], v[2]);
            hold(2 * BIT_CLK);
            check_eq($sformatf("R3 vec%0d delivered once", i), vcnt, v0 + 1);
            check_eq($sformatf("R3 vec%0d data", i), int'(last_data), int'(v[11:3]));
            check_eq($sformatf("R4 vec%0d parity flag", i), int'(last_pe), int'(v[1]));
            check_eq($sformatf("R5 vec%0d framing flag", i), int'(last_fe), int'(v[0]));
        end
        par_en   = 1'b0;
        nine_bit = 1'b0;

        // R2: a short low glitch is not a start bit.
        hold(2 * BIT_CLK);
        v0 = vcnt;
        rx_in = 1'b0;
        hold(12);
        rx_in = 1'b1;
        hold(12 * BIT_CLK);
        check_eq("R2 glitch rejected", vcnt, v0);

        // R7: counting from the start bit makes trailing 1s count.
        idle_after_stop = 1'b0;
        hold(12 * BIT_CLK);
        i0 = icnt;
        send_frame(8, 9'h0FF, 1'b0);
        hold(96);
        check_eq("R7 early idle after all-ones char", icnt, i0 + 1);

        // R8: counting from the stop bit delays idle by a full length.
        idle_after_stop = 1'b1;
        hold(12 * BIT_CLK);
        i0 = icnt;
        send_frame(8, 9'h0FF, 1'b0);
        hold(96);
        check_eq("R8 no early idle", icnt, i0);
        hold(576);
        check_eq("R8 idle after stop-based count", icnt, i0 + 1);

        // R6: 8-bit idle length measured from the stop bit.
        hold(4 * BIT_CLK);
        i0 = icnt;
        send_frame(8, 9'h000, 1'b0);
        hold(640);
        check_eq("R6 8-bit idle at 10 bits", icnt, i0 + 1);

        // R6: 9-bit mode needs 11 bit times.
        nine_bit = 1'b1;
        hold(4 * BIT_CLK);
        i0 = icnt;
        send_frame(9, 9'h000, 1'b0);
        hold(640);
        check_eq("R6 9-bit idle not at 10 bits", icnt, i0);
        hold(100);
        check_eq("R6 9-bit idle at 11 bits", icnt, i0 + 1);

        // R9 R10: address-mark wakeup, 8-bit.
        nine_bit  = 1'b0;
        wake_addr = 1'b1;
        hold(2 * BIT_CLK);
        pulse_sleep();
        check_eq("R9 sleep entered", int'(asleep), 1);
        v0 = vcnt;
        send_frame(8, 9'h041, 1'b0);
        hold(2 * BIT_CLK);
        check_eq("R9 unmarked char suppressed", vcnt, v0);
        check_eq("R10 unmarked char keeps sleep", int'(asleep), 1);
        send_frame(8, 9'h0C1, 1'b0);
        hold(2 * BIT_CLK);
        check_eq("R10 marked char delivered", vcnt, v0 + 1);
        check_eq("R10 marked char data", int'(last_data), 'h0C1);
        check_eq("R10 marked char wakes", int'(asleep), 0);
        send_frame(8, 9'h022, 1'b0);
        hold(2 * BIT_CLK);
        check_eq("R10 delivery after wake", int'(last_data), 'h022);

        // R10: address-mark wakeup, 9-bit, top bit is bit 8.
        nine_bit = 1'b1;
        hold(2 * BIT_CLK);
        pulse_sleep();
        v0 = vcnt;
        send_frame(9, 9'h0FF, 1'b0);
        hold(2 * BIT_CLK);
        check_eq("R10 9-bit bit7 set does not wake", int'(asleep), 1);
        check_eq("R9 9-bit unmarked suppressed", vcnt, v0);
        send_frame(9, 9'h155, 1'b0);
        hold(2 * BIT_CLK);
        check_eq("R10 9-bit marked delivered", int'(last_data), 'h155);
        check_eq("R10 9-bit marked wakes", int'(asleep), 0);

        // R11: idle-line wakeup.
        nine_bit        = 1'b0;
        wake_addr       = 1'b0;
        idle_after_stop = 1'b1;
        hold(12 * BIT_CLK);
        pulse_sleep();
        hold(2 * BIT_CLK);
        check_eq("R11 no wake without new idle", int'(asleep), 1);
        i0 = icnt;
        v0 = vcnt;
        send_frame(8, 9'h092, 1'b0);
        hold(32);
        check_eq("R11 marked char does not wake", int'(asleep), 1);
        check_eq("R9 char suppressed in idle mode", vcnt, v0);
        hold(12 * BIT_CLK);
        check_eq("R11 idle pulse seen", icnt, i0 + 1);
        check_eq("R11 idle wakes", int'(asleep), 0);
        send_frame(8, 9'h034, 1'b0);
        hold(2 * BIT_CLK);
        check_eq("R11 delivery after wake", int'(last_data), 'h034);
        check_eq("R11 delivery count", vcnt, v0 + 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule